// File: doc/BRIEF.md
# 32-bit Virtual Address Segment Translator

This block is the translation front end that sits between a load/store unit and a TLB. It sorts each 32-bit virtual address into a privilege segment. Depending on the segment, the access is passed through to a fixed physical window, sent on to the TLB, or rejected as an address error. A mode input replaces every TLB-mapped segment with a fixed offset mapping, so the same front end serves a core built without a TLB.

When an access faults, whether from a segment violation or from the TLB result, the block gives an exception cause code and a refill indication. On the next clock edge it also loads three capture registers: the faulting address, a context word holding the page-table index, and an entry-high word holding the page-pair tag. The TLB lookup itself and exception vectoring are done elsewhere. The translation outputs are combinational from the request, and the capture registers change one edge later.

Top module: `vseg_xlate`

## Requirements
- R1: With `user_i`=1, any address with bit 31 set is an address error: `fault_o`=1, `refill_o`=0, and `cause_o` is 4 for a read or 5 for a write.
- R2: With no address error, addresses 0x80000000–0x9FFFFFFF are unmapped: `paddr_o` is the address minus 0x80000000, `perm_o`=2'b11, and there is no fault whatever the TLB inputs are.
- R3: With no address error, addresses 0xA0000000–0xBFFFFFFF are unmapped: `paddr_o` is the address minus 0xA0000000, `perm_o`=2'b11, and there is no fault.
- R4: In TLB mode (`fixed_map_i`=0), the mapped regions are 0x00000000–0x7FFFFFFF (except under R5) and 0xC0000000–0xFFFFFFFF. In these regions a `tlb_res_i`=2'b00 (hit) that is not a dirty fault gives `paddr_o`=`tlb_paddr_i` and `perm_o`={`tlb_dirty_i`,1}. `perm_o` bit 0 is read and bit 1 is write.
- R5: With `erl_i`=1 and `user_i`=1, addresses 0x00000000–0x7FFFFFFF pass through unchanged with `perm_o`=2'b11 and no fault, and the TLB inputs are ignored.
- R6: In fixed mode (`fixed_map_i`=1), the mapped regions never fault. The low half maps to address+0x40000000 when `erl_i`=0 and maps unchanged when `erl_i`=1. 0xC0000000 and above map unchanged. `perm_o`=2'b11.
- R7: In TLB mode, in a mapped region, `tlb_res_i`=2'b01 (no match) gives cause 2 on a read or 3 on a write with `refill_o`=1. `tlb_res_i`=2'b10 (invalid) gives the same causes with `refill_o`=0.
- R8: In TLB mode, a hit with `tlb_dirty_i`=0 gives a fault with cause 1 on a write. On a read it translates read-only (`perm_o`=2'b01).
- R9: After a clock edge at which `valid_i`=1 and `fault_o`=1, `badvaddr_o` holds the full faulting address.
- R10: On the same capture, `context_o[22:4]` takes address bits 31:13 and `context_o[3:0]` becomes 0, while `context_o[31:23]` holds its value (zero from reset).
- R11: On the same capture, `entryhi_o[31:13]` takes address bits 31:13 and `entryhi_o[12:8]` becomes 0, while the ASID field `entryhi_o[7:0]` holds its value (zero from reset).
- R12: The capture registers reset to zero and hold on every edge without a valid fault. With `valid_i`=0, `paddr_o`, `perm_o`, `fault_o`, `cause_o` and `refill_o` are all zero. On any fault, `paddr_o` and `perm_o` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Access request present |
| vaddr_i | input | 32 | Virtual address |
| write_i | input | 1 | 1 = store, 0 = load |
| user_i | input | 1 | Access is made in user mode |
| erl_i | input | 1 | Error-level status bit |
| fixed_map_i | input | 1 | 1 = fixed offset mapping instead of TLB |
| tlb_res_i | input | 2 | TLB lookup: 00 hit, 01 no match, 10 invalid |
| tlb_dirty_i | input | 1 | Dirty (writable) bit of the hit page |
| tlb_paddr_i | input | 32 | Physical address from the TLB on a hit |
| paddr_o | output | 32 | Physical address |
| perm_o | output | 2 | Permissions {write, read} |
| fault_o | output | 1 | Access faults |
| cause_o | output | 5 | Exception cause code |
| refill_o | output | 1 | Fault needs the refill handler |
| badvaddr_o | output | 32 | Captured faulting address |
| context_o | output | 32 | Captured context word |
| entryhi_o | output | 32 | Captured entry-high word |

## Verification
Translation, fault, cause and refill outputs are combinational, so they are due in the same cycle as the request. The bench drives each request just after a falling edge and samples these outputs 1 ns later, before the next rising edge. The three capture registers are due one rising edge after a faulting request, so the bench samples them 1 ns after that edge. It compares them against a running model that is updated only for valid faulting requests, so a missed hold shows up as a mismatch just as a missed load does.

// File: rtl/vseg_pkg.sv
package vseg_pkg;
  typedef enum logic [1:0] {
    TLB_HIT   = 2'b00,
    TLB_MISS  = 2'b01,
    TLB_INVAL = 2'b10,
    TLB_RSVD  = 2'b11
  } tlb_res_e;

  typedef enum logic [1:0] {
    ROUTE_DIRECT = 2'b00,
    ROUTE_TLB    = 2'b01,
    ROUTE_ADERR  = 2'b10
  } route_e;

  localparam logic [4:0] CAUSE_MOD  = 5'd1;
  localparam logic [4:0] CAUSE_TLBL = 5'd2;
  localparam logic [4:0] CAUSE_TLBS = 5'd3;
  localparam logic [4:0] CAUSE_ADEL = 5'd4;
  localparam logic [4:0] CAUSE_ADES = 5'd5;

  localparam logic [31:0] FIXED_LOW_OFFSET = 32'h4000_0000;
endpackage

// File: rtl/vseg_decode.sv
module vseg_decode
  import vseg_pkg::*;
(
  input  logic [31:0] vaddr_i,
  input  logic        user_i,
  input  logic        erl_i,
  input  logic        fixed_map_i,
  output route_e      route_o,
  output logic [31:0] direct_pa_o
);
  logic [2:0] seg;
  assign seg = vaddr_i[31:29];

  always_comb begin
    route_o     = ROUTE_DIRECT;
    direct_pa_o = vaddr_i;
    if (user_i && vaddr_i[31]) begin
      route_o = ROUTE_ADERR;
    end else begin
      unique case (seg)
        3'b100, 3'b101: direct_pa_o = {3'b000, vaddr_i[28:0]};
        3'b110, 3'b111: begin
          if (!fixed_map_i) route_o = ROUTE_TLB;
        end
        default: begin
          // low half: error level in user mode bypasses mapping
          if (!(erl_i && user_i)) begin
            if (fixed_map_i) begin
              if (!erl_i) direct_pa_o = vaddr_i + FIXED_LOW_OFFSET;
            end else begin
              route_o = ROUTE_TLB;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/vseg_fault_map.sv
module vseg_fault_map
  import vseg_pkg::*;
(
  input  logic        valid_i,
  input  logic        write_i,
  input  route_e      route_i,
  input  logic [31:0] direct_pa_i,
  input  tlb_res_e    tlb_res_i,
  input  logic        tlb_dirty_i,
  input  logic [31:0] tlb_paddr_i,
  output logic [31:0] paddr_o,
  output logic [1:0]  perm_o,
  output logic        fault_o,
  output logic [4:0]  cause_o,
  output logic        refill_o
);
  always_comb begin
    paddr_o  = '0;
    perm_o   = '0;
    fault_o  = 1'b0;
    cause_o  = '0;
    refill_o = 1'b0;
    if (valid_i) begin
      unique case (route_i)
        ROUTE_ADERR: begin
          fault_o = 1'b1;
          cause_o = write_i ? CAUSE_ADES : CAUSE_ADEL;
        end
        ROUTE_TLB: begin
          if (tlb_res_i == TLB_HIT) begin
            if (write_i && !tlb_dirty_i) begin
              fault_o = 1'b1;
              cause_o = CAUSE_MOD;
            end else begin
              paddr_o = tlb_paddr_i;
              perm_o  = {tlb_dirty_i, 1'b1};
            end
          end else begin
            fault_o  = 1'b1;
            cause_o  = write_i ? CAUSE_TLBS : CAUSE_TLBL;
            refill_o = (tlb_res_i == TLB_MISS);
          end
        end
        default: begin
          paddr_o = direct_pa_i;
          perm_o  = 2'b11;
        end
      endcase
    end
  end
endmodule

// File: rtl/vseg_capture.sv
module vseg_capture #(
  parameter int ASID_W   = 8,
  parameter int PAGE_LSB = 13,
  parameter int CTX_LSB  = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        load_i,
  input  logic [31:0] vaddr_i,
  output logic [31:0] badvaddr_o,
  output logic [31:0] context_o,
  output logic [31:0] entryhi_o
);
  localparam int VPN_W = 32 - PAGE_LSB;
  localparam int CTX_W = VPN_W + CTX_LSB;

  logic [VPN_W-1:0] vpn;
  assign vpn = vaddr_i[31:PAGE_LSB];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      badvaddr_o <= '0;
      context_o  <= '0;
      entryhi_o  <= '0;
    end else if (load_i) begin
      badvaddr_o               <= vaddr_i;
      context_o[CTX_W-1:0]     <= {vpn, {CTX_LSB{1'b0}}};
      entryhi_o[31:ASID_W]     <= {vpn, {(PAGE_LSB-ASID_W){1'b0}}};
    end
  end
endmodule

// File: rtl/vseg_xlate.sv
module vseg_xlate
  import vseg_pkg::*;
#(
  parameter int ASID_W   = 8,
  parameter int PAGE_LSB = 13,
  parameter int CTX_LSB  = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        valid_i,
  input  logic [31:0] vaddr_i,
  input  logic        write_i,
  input  logic        user_i,
  input  logic        erl_i,
  input  logic        fixed_map_i,
  input  logic [1:0]  tlb_res_i,
  input  logic        tlb_dirty_i,
  input  logic [31:0] tlb_paddr_i,
  output logic [31:0] paddr_o,
  output logic [1:0]  perm_o,
  output logic        fault_o,
  output logic [4:0]  cause_o,
  output logic        refill_o,
  output logic [31:0] badvaddr_o,
  output logic [31:0] context_o,
  output logic [31:0] entryhi_o
);
  route_e      route;
  logic [31:0] direct_pa;

  vseg_decode u_decode (
    .vaddr_i     (vaddr_i),
    .user_i      (user_i),
    .erl_i       (erl_i),
    .fixed_map_i (fixed_map_i),
    .route_o     (route),
    .direct_pa_o (direct_pa)
  );

  vseg_fault_map u_fault (
    .valid_i     (valid_i),
    .write_i     (write_i),
    .route_i     (route),
    .direct_pa_i (direct_pa),
    .tlb_res_i   (tlb_res_e'(tlb_res_i)),
    .tlb_dirty_i (tlb_dirty_i),
    .tlb_paddr_i (tlb_paddr_i),
    .paddr_o     (paddr_o),
    .perm_o      (perm_o),
    .fault_o     (fault_o),
    .cause_o     (cause_o),
    .refill_o    (refill_o)
  );

  vseg_capture #(
    .ASID_W   (ASID_W),
    .PAGE_LSB (PAGE_LSB),
    .CTX_LSB  (CTX_LSB)
  ) u_capture (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (valid_i && fault_o),
    .vaddr_i    (vaddr_i),
    .badvaddr_o (badvaddr_o),
    .context_o  (context_o),
    .entryhi_o  (entryhi_o)
  );
endmodule

// File: rtl/vseg_xlate_chk.sv
module vseg_xlate_chk #(
  parameter int ASID_W = 8
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [31:0] vaddr_i,
  input logic        write_i,
  input logic        user_i,
  input logic [1:0]  perm_o,
  input logic        fault_o,
  input logic [4:0]  cause_o,
  input logic        refill_o,
  input logic [31:0] badvaddr_o,
  input logic [31:0] context_o,
  input logic [31:0] entryhi_o
);
  assert_user_kernel_aderr_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && user_i && vaddr_i[31]) |->
      (fault_o && !refill_o && cause_o == (write_i ? 5'd5 : 5'd4)));

  assert_refill_is_tlb_fault_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refill_o |-> (fault_o && (cause_o == 5'd2 || cause_o == 5'd3)));

  assert_badvaddr_capture_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && fault_o) |=> (badvaddr_o == $past(vaddr_i)));

  assert_entryhi_tag_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && fault_o) |=> (entryhi_o[31:13] == $past(vaddr_i[31:13]) && entryhi_o[12:ASID_W] == '0));

  assert_capture_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && fault_o) |=> ($stable(badvaddr_o) && $stable(context_o) && $stable(entryhi_o)));

  assert_idle_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> (!fault_o && !refill_o && perm_o == 2'b00));

  assert_fault_no_perm_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (perm_o == 2'b00));
endmodule

bind vseg_xlate vseg_xlate_chk #(.ASID_W(ASID_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .vaddr_i    (vaddr_i),
  .write_i    (write_i),
  .user_i     (user_i),
  .perm_o     (perm_o),
  .fault_o    (fault_o),
  .cause_o    (cause_o),
  .refill_o   (refill_o),
  .badvaddr_o (badvaddr_o),
  .context_o  (context_o),
  .entryhi_o  (entryhi_o)
);

// File: tb/vseg_xlate_tb.sv
module vseg_xlate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [31:0] vaddr = '0;
  logic        write = 1'b0;
  logic        user = 1'b0;
  logic        erl = 1'b0;
  logic        fixed_map = 1'b0;
  logic [1:0]  tlb_res = 2'b00;
  logic        tlb_dirty = 1'b0;
  logic [31:0] tlb_paddr = '0;
  logic [31:0] paddr;
  logic [1:0]  perm;
  logic        fault;
  logic [4:0]  cause;
  logic        refill;
  logic [31:0] badvaddr, context_w, entryhi;

  int checks = 0;
  int errors = 0;
  logic [31:0] m_bad = '0, m_ctx = '0, m_eh = '0;

  always #2 clk = ~clk;

  vseg_xlate u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .vaddr_i(vaddr),
    .write_i(write), .user_i(user), .erl_i(erl), .fixed_map_i(fixed_map),
    .tlb_res_i(tlb_res), .tlb_dirty_i(tlb_dirty), .tlb_paddr_i(tlb_paddr),
    .paddr_o(paddr), .perm_o(perm), .fault_o(fault), .cause_o(cause),
    .refill_o(refill), .badvaddr_o(badvaddr), .context_o(context_w),
    .entryhi_o(entryhi)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s vaddr=%h act=%h exp=%h", tag, vaddr, act, exp);
    end
  endtask

  function automatic logic [31:0] pick_addr(input int i);
    case (i)
      0: return 32'h0000_0000;   1: return 32'h1234_5678;
      2: return 32'h7FFF_FFFF;   3: return 32'h8000_0000;
      4: return 32'h9FFF_FFFF;   5: return 32'hA000_0000;
      6: return 32'hBFFF_FFFF;   7: return 32'hC000_0000;
      8: return 32'hDEAD_BEEF;   9: return 32'hE000_0000;
      10: return 32'hFFFF_FFFF;  default: return 32'h3FFF_E123;
    endcase
  endfunction

  // one request: combinational check before the edge, capture check after it
  task automatic run_one();
    logic [31:0] e_pa;
    logic [1:0]  e_perm;
    logic        e_fault, e_refill, mapped;
    logic [4:0]  e_cause;
    string       tag;
    e_pa = '0; e_perm = '0; e_fault = 0; e_refill = 0; e_cause = '0; mapped = 0;
    if (!valid) tag = "R12";
    else if (user && vaddr > 32'h7FFF_FFFF) begin
      tag = "R1"; e_fault = 1; e_cause = write ? 5'd5 : 5'd4;
    end else if (vaddr < 32'h8000_0000) begin
      if (erl && user) begin tag = "R5"; e_pa = vaddr; e_perm = 2'b11; end
      else mapped = 1;
    end else if (vaddr < 32'hA000_0000) begin
      tag = "R2"; e_pa = vaddr - 32'h8000_0000; e_perm = 2'b11;
    end else if (vaddr < 32'hC000_0000) begin
      tag = "R3"; e_pa = vaddr - 32'hA000_0000; e_perm = 2'b11;
    end else mapped = 1;
    if (mapped) begin
      if (fixed_map) begin
        tag = "R6"; e_perm = 2'b11;
        e_pa = (vaddr < 32'h8000_0000 && !erl) ? vaddr + 32'h4000_0000 : vaddr;
      end else if (tlb_res != 2'b00) begin
        tag = "R7"; e_fault = 1; e_cause = write ? 5'd3 : 5'd2;
        e_refill = (tlb_res == 2'b01);
      end else if (!tlb_dirty) begin
        tag = "R8";
        if (write) begin e_fault = 1; e_cause = 5'd1; end
        else begin e_pa = tlb_paddr; e_perm = 2'b01; end
      end else begin
        tag = "R4"; e_pa = tlb_paddr; e_perm = 2'b11;
      end
    end
    #1;
    check(tag, {23'b0, paddr, perm, fault, cause, refill},
               {23'b0, e_pa, e_perm, e_fault, e_cause, e_refill});
    if (valid && e_fault) begin
      m_bad = vaddr;
      m_ctx = {m_ctx[31:23], vaddr[31:13], 4'b0};
      m_eh  = {vaddr[31:13], 5'b0, m_eh[7:0]};
    end
    @(posedge clk); #1;
    check((valid && e_fault) ? "R9"  : "R12", {32'b0, badvaddr},  {32'b0, m_bad});
    check((valid && e_fault) ? "R10" : "R12", {32'b0, context_w}, {32'b0, m_ctx});
    check((valid && e_fault) ? "R11" : "R12", {32'b0, entryhi},   {32'b0, m_eh});
  endtask

  initial begin : watchdog
    #400000;
    errors++;
    $display("FAIL watchdog timeout");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R12 reset", {badvaddr, context_w}, 64'h0);
    check("R12 reset", {32'b0, entryhi}, 64'h0);
    rst_n = 1'b1;
    for (int v = 0; v < 2; v++)
      for (int f = 0; f < 2; f++)
        for (int u = 0; u < 2; u++)
          for (int e = 0; e < 2; e++)
            for (int w = 0; w < 2; w++)
              for (int s = 0; s < 3; s++)
                for (int d = 0; d < 2; d++)
                  for (int a = 0; a < 12; a++) begin
                    @(negedge clk);
                    valid = v[0]; fixed_map = f[0]; user = u[0]; erl = e[0];
                    write = w[0]; tlb_res = s[1:0]; tlb_dirty = d[0];
                    vaddr = pick_addr(a);
                    tlb_paddr = ~vaddr ^ 32'h0F0F_0F0F;
                    run_one();
                  end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule